// File: doc/BRIEF.md
# I2C Slave Data Buffer With Overrun and Underrun Flagging

This block is the data-holding stage of an I2C slave that never holds SCL low to wait for software. Incoming bytes arrive from the bit shifter as a one-cycle strobe. Outgoing bytes are handed to the shifter when it raises a request strobe. Because the bus never waits, software can fall behind in either direction. The block detects both cases and keeps running under fixed rules. On a receive overrun, the unread byte is kept and the new one is dropped. On a transmit underrun, the byte already held is sent again. Either event raises a sticky error flag that software must clear.

A receive-full flag and a transmit-empty flag tell software when to read and when to write. An address-match indication from the address logic opens a transmit transfer. The software clear of that address flag marks the point after which the first outgoing byte may be written. A byte written before that point does not count, so the first byte goes out as an underrun.

Top module: `i2c_nostretch_dbuf`

## Requirements
- R1: After reset, `rx_full` is 0, `tx_empty` is 1, `err_flag` is 0, `tx_byte` is all zeros and `sw_rdata` is all zeros.
- R2: A `rx_done` strobe while `rx_full` is 0 stores `rx_byte`. One cycle later, `rx_full` is 1 and `sw_rdata` shows the stored byte.
- R3: A `sw_rd` strobe clears `rx_full` on the next cycle. If `sw_rd` and `rx_done` arrive in the same cycle, the new byte is stored and `rx_full` stays 1. This case is not an overrun.
- R4: Overrun is a `rx_done` strobe while `rx_full` is 1 and no `sw_rd` arrives in the same cycle. The new byte is discarded, `sw_rdata` keeps the earlier byte, `rx_full` stays 1, and `err_flag` is set when detection is enabled.
- R5: A `sw_wr` strobe, accepted while the address flag is clear, loads `sw_wdata` into the transmit holding register. It clears `tx_empty` on the next cycle, unless a `tx_req` or `addr_match` arrives in the same cycle.
- R6: A `tx_req` strobe copies the holding register to `tx_byte` and sets `tx_empty` on the next cycle. If an accepted `sw_wr` arrives in the same cycle, the newly written byte is the one copied, and this case is not an underrun.
- R7: Underrun is a `tx_req` while `tx_empty` is 1 with no accepted write in the same cycle. `tx_byte` takes the byte already held, so the previous byte is sent again, and `err_flag` is set when detection is enabled.
- R8: Detection is enabled only while `slave_en` and `stretch_off` are both 1. With detection disabled, the data and the flags behave the same, but `err_flag` is not set.
- R9: An `addr_match` strobe sets an internal address flag. When `dir_tx` is 1, it also sets `tx_empty`. `sw_wr` is ignored from the `addr_match` cycle until `addr_clr` clears the flag. So the first `tx_req` after a match with no later write resends the held byte as an underrun.
- R10: `err_flag` stays set until an `err_clr` strobe clears it. Clearing the flag leaves `rx_full`, `tx_empty` and both data bytes unchanged.
- R11: When `err_clr` and a new overrun or underrun fall in the same cycle, `err_flag` is 1 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| slave_en | input | 1 | Slave mode active |
| stretch_off | input | 1 | Clock stretching disabled |
| dir_tx | input | 1 | 1 = slave transmits, 0 = slave receives |
| addr_match | input | 1 | Strobe: own address matched, sets the address flag |
| addr_clr | input | 1 | Strobe: software cleared the address flag |
| rx_done | input | 1 | Strobe: shifter finished receiving a byte |
| rx_byte | input | DW | Byte from the shifter, valid with `rx_done` |
| tx_req | input | 1 | Strobe: shifter starts the next outgoing byte |
| sw_wr | input | 1 | Software write strobe |
| sw_wdata | input | DW | Software write data |
| sw_rd | input | 1 | Software read strobe |
| err_clr | input | 1 | Software clear of the error flag |
| sw_rdata | output | DW | Held received byte |
| rx_full | output | 1 | Received byte waiting to be read |
| tx_empty | output | 1 | Transmit holding register needs a new byte |
| tx_byte | output | DW | Byte handed to the shifter |
| err_flag | output | 1 | Sticky overrun/underrun error |

## Verification
Two pairs of functions can coincide in one cycle. A software read can meet a byte arrival, and a software write can meet a transfer request. In both pairs the software action must win, so the cycle counts as neither an overrun nor an underrun. An error clear can also coincide with a fresh error event, and then the event must win. Directed steps force each collision once. A random phase then applies all strobes independently with fixed probabilities, so every collision recurs many times. After each edge, a bench reference model predicts the flags and both bytes, and the outputs are compared with it.

// File: rtl/i2cdb_pkg.sv
package i2cdb_pkg;
  localparam int unsigned DATA_W_DEF = 8;
  localparam int unsigned SYNC_STAGES_DEF = 2;

  typedef struct packed {
    logic ovr;
    logic udr;
  } err_ev_t;
endpackage

// File: rtl/i2cdb_rst_sync.sv
module i2cdb_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/i2cdb_rx_hold.sv
module i2cdb_rx_hold #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_done,
  input  logic [DW-1:0] rx_byte,
  input  logic          sw_rd,
  output logic [DW-1:0] rdata,
  output logic          full,
  output logic          ovr_hit
);
  logic [DW-1:0] hold_q, hold_d;
  logic          full_q, full_d;
  logic          load_en;

  always_comb begin
    load_en = rx_done && (!full_q || sw_rd);
    ovr_hit = rx_done && full_q && !sw_rd;
    hold_d  = rx_byte;
    if (load_en)    full_d = 1'b1;
    else if (sw_rd) full_d = 1'b0;
    else            full_d = full_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      full_q <= 1'b0;
    end else begin
      if (load_en) hold_q <= hold_d;
      full_q <= full_d;
    end
  end

  assign rdata = hold_q;
  assign full  = full_q;

  // R4
  ovr_keeps_old_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_hit |=> full && $stable(rdata));
  // R3
  rd_clears_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_rd && !rx_done) |=> !full);
  // R3
  rd_and_rx_same_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_rd && rx_done) |=> full && (rdata == $past(rx_byte)));
endmodule

// File: rtl/i2cdb_tx_hold.sv
module i2cdb_tx_hold #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dir_tx,
  input  logic          addr_match,
  input  logic          addr_clr,
  input  logic          sw_wr,
  input  logic [DW-1:0] sw_wdata,
  input  logic          tx_req,
  output logic          empty,
  output logic [DW-1:0] tx_byte,
  output logic          udr_hit
);
  logic [DW-1:0] hold_q, hold_d;
  logic [DW-1:0] shift_q;
  logic          empty_q, empty_d;
  logic          apend_q, apend_d;
  logic          wr_ok;

  always_comb begin
    wr_ok   = sw_wr && !apend_q && !addr_match;
    udr_hit = tx_req && empty_q && !wr_ok;
    hold_d  = wr_ok ? sw_wdata : hold_q;
    if (tx_req || (addr_match && dir_tx)) empty_d = 1'b1;
    else if (wr_ok)                       empty_d = 1'b0;
    else                                  empty_d = empty_q;
    if (addr_match)    apend_d = 1'b1;
    else if (addr_clr) apend_d = 1'b0;
    else               apend_d = apend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= '0;
      shift_q <= '0;
      empty_q <= 1'b1;
      apend_q <= 1'b0;
    end else begin
      if (wr_ok)  hold_q  <= hold_d;
      if (tx_req) shift_q <= hold_d;
      empty_q <= empty_d;
      apend_q <= apend_d;
    end
  end

  assign empty   = empty_q;
  assign tx_byte = shift_q;

  // R6
  req_sets_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req |=> empty);
  // R5
  wr_clears_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr && !apend_q && !addr_match && !tx_req) |=> !empty);
  // R9
  wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr && apend_q && !tx_req && !addr_match) |=> $stable(empty) && $stable(hold_q));
  // R7
  udr_resend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    udr_hit |=> $stable(hold_q) && (tx_byte == hold_q));
endmodule

// File: rtl/i2cdb_err_flag.sv
module i2cdb_err_flag
  import i2cdb_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    det_en,
  input  err_ev_t ev,
  input  logic    err_clr,
  output logic    err
);
  logic err_q, err_d, hit;

  always_comb begin
    hit = det_en && (ev.ovr || ev.udr);
    if (hit)          err_d = 1'b1;
    else if (err_clr) err_d = 1'b0;
    else              err_d = err_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign err = err_q;

  // R11
  event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (det_en && (ev.ovr || ev.udr)) |=> err);
  // R10
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !err_clr) |=> err);
  // R10
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr && !(det_en && (ev.ovr || ev.udr))) |=> !err);
  // R8
  no_detect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!det_en && !err) |=> !err);
endmodule

// File: rtl/i2c_nostretch_dbuf.sv
module i2c_nostretch_dbuf
  import i2cdb_pkg::*;
#(
  parameter int unsigned DW          = DATA_W_DEF,
  parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slave_en,
  input  logic          stretch_off,
  input  logic          dir_tx,
  input  logic          addr_match,
  input  logic          addr_clr,
  input  logic          rx_done,
  input  logic [DW-1:0] rx_byte,
  input  logic          tx_req,
  input  logic          sw_wr,
  input  logic [DW-1:0] sw_wdata,
  input  logic          sw_rd,
  input  logic          err_clr,
  output logic [DW-1:0] sw_rdata,
  output logic          rx_full,
  output logic          tx_empty,
  output logic [DW-1:0] tx_byte,
  output logic          err_flag
);
  logic    srst_n;
  logic    det_en;
  err_ev_t ev;

  assign det_en = slave_en && stretch_off;

  i2cdb_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .srst_n(srst_n)
  );

  i2cdb_rx_hold #(.DW(DW)) u_rx (
    .clk(clk), .rst_n(srst_n), .rx_done(rx_done), .rx_byte(rx_byte),
    .sw_rd(sw_rd), .rdata(sw_rdata), .full(rx_full), .ovr_hit(ev.ovr)
  );

  i2cdb_tx_hold #(.DW(DW)) u_tx (
    .clk(clk), .rst_n(srst_n), .dir_tx(dir_tx), .addr_match(addr_match),
    .addr_clr(addr_clr), .sw_wr(sw_wr), .sw_wdata(sw_wdata), .tx_req(tx_req),
    .empty(tx_empty), .tx_byte(tx_byte), .udr_hit(ev.udr)
  );

  i2cdb_err_flag u_err (
    .clk(clk), .rst_n(srst_n), .det_en(det_en), .ev(ev),
    .err_clr(err_clr), .err(err_flag)
  );

  // R10
  clr_keeps_flags_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (err_clr && !rx_done && !sw_rd && !tx_req && !sw_wr && !addr_match)
      |=> $stable(rx_full) && $stable(tx_empty));
endmodule

// File: tb/i2c_nostretch_dbuf_bench.sv
module i2c_nostretch_dbuf_bench;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic slave_en, stretch_off, dir_tx, addr_match, addr_clr;
  logic rx_done, tx_req, sw_wr, sw_rd, err_clr;
  logic [DW-1:0] rx_byte, sw_wdata;
  logic [DW-1:0] sw_rdata, tx_byte;
  logic rx_full, tx_empty, err_flag;

  int n_chk = 0;
  int n_bad = 0;

  // reference model state
  logic [DW-1:0] m_dr, m_txd, m_txb;
  logic m_rxne, m_txe, m_err, m_apend;

  always #10 clk = ~clk;

  i2c_nostretch_dbuf u_i2c_nostretch_dbuf (
    .clk(clk), .rst_n(rst_n), .slave_en(slave_en), .stretch_off(stretch_off),
    .dir_tx(dir_tx), .addr_match(addr_match), .addr_clr(addr_clr),
    .rx_done(rx_done), .rx_byte(rx_byte), .tx_req(tx_req), .sw_wr(sw_wr),
    .sw_wdata(sw_wdata), .sw_rd(sw_rd), .err_clr(err_clr),
    .sw_rdata(sw_rdata), .rx_full(rx_full), .tx_empty(tx_empty),
    .tx_byte(tx_byte), .err_flag(err_flag)
  );

  task automatic cmp(input string tag, input string what, input logic [DW-1:0] got,
                     input logic [DW-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  task automatic model_step();
    logic det, ovr, wr_ok, udr;
    logic [DW-1:0] new_txd;
    det   = slave_en && stretch_off;
    ovr   = rx_done && m_rxne && !sw_rd;
    wr_ok = sw_wr && !m_apend && !addr_match;
    udr   = tx_req && m_txe && !wr_ok;
    if (rx_done && (!m_rxne || sw_rd)) begin m_dr = rx_byte; m_rxne = 1'b1; end
    else if (sw_rd) m_rxne = 1'b0;
    new_txd = wr_ok ? sw_wdata : m_txd;
    if (tx_req) m_txb = new_txd;
    if (tx_req || (addr_match && dir_tx)) m_txe = 1'b1;
    else if (wr_ok) m_txe = 1'b0;
    m_txd = new_txd;
    if (addr_match) m_apend = 1'b1;
    else if (addr_clr) m_apend = 1'b0;
    if (det && (ovr || udr)) m_err = 1'b1;
    else if (err_clr) m_err = 1'b0;
  endtask

  task automatic clear_strobes();
    addr_match = 0; addr_clr = 0; rx_done = 0; tx_req = 0;
    sw_wr = 0; sw_rd = 0; err_clr = 0;
  endtask

  task automatic step(input string tag);
    model_step();
    @(posedge clk); #1;
    cmp(tag, "rx_full",  {7'b0, rx_full},  {7'b0, m_rxne});
    cmp(tag, "tx_empty", {7'b0, tx_empty}, {7'b0, m_txe});
    cmp(tag, "err_flag", {7'b0, err_flag}, {7'b0, m_err});
    cmp(tag, "sw_rdata", sw_rdata, m_dr);
    cmp(tag, "tx_byte",  tx_byte,  m_txb);
    @(negedge clk);
    clear_strobes();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1C2D_5EED));
    rst_n = 0; slave_en = 1; stretch_off = 1; dir_tx = 0;
    rx_byte = 0; sw_wdata = 0;
    clear_strobes();
    m_dr = 0; m_txd = 0; m_txb = 0; m_rxne = 0; m_txe = 1; m_err = 0; m_apend = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    step("R1 reset");

    // receive path
    rx_done = 1; rx_byte = 8'hA5;          step("R2 first byte");
    rx_done = 1; rx_byte = 8'h3C;          step("R4 overrun");
    err_clr = 1;                           step("R10 clear keeps rx_full");
    sw_rd = 1; rx_done = 1; rx_byte = 8'h77; step("R3 read with arrival");
    sw_rd = 1;                             step("R3 read clears");

    // transmit path
    dir_tx = 1;
    sw_wr = 1; sw_wdata = 8'h5A;           step("R5 write");
    tx_req = 1;                            step("R6 transfer");
    tx_req = 1;                            step("R7 underrun resend");
    err_clr = 1; tx_req = 1;               step("R11 clear vs underrun");
    err_clr = 1;                           step("R10 clear");

    // detection disabled
    stretch_off = 0;
    rx_done = 1; rx_byte = 8'h11;          step("R8 store");
    rx_done = 1; rx_byte = 8'h22;          step("R8 no flag on overrun");
    tx_req = 1;                            step("R8 no flag on underrun");
    stretch_off = 1; slave_en = 0;
    tx_req = 1;                            step("R8 slave off");
    slave_en = 1;
    sw_rd = 1;                             step("R3 drain");

    // address flag and first byte
    sw_wr = 1; sw_wdata = 8'hC3;           step("R5 preload");
    addr_match = 1;                        step("R9 match sets empty");
    sw_wr = 1; sw_wdata = 8'h99;           step("R9 write ignored");
    tx_req = 1;                            step("R9 first byte underrun");
    addr_clr = 1; err_clr = 1;             step("R9 flag cleared");
    sw_wr = 1; sw_wdata = 8'h99;           step("R5 write after clear");
    tx_req = 1;                            step("R6 new byte sent");
    sw_wr = 1; sw_wdata = 8'h4E; tx_req = 1; step("R6 write with request");

    // random phase
    for (int i = 0; i < 4000; i++) begin
      slave_en    = ($urandom % 10) != 0;
      stretch_off = ($urandom % 8) != 0;
      if (($urandom % 16) == 0) dir_tx = ~dir_tx;
      rx_done    = ($urandom % 4) == 0;
      rx_byte    = DW'($urandom);
      sw_rd      = ($urandom % 3) == 0;
      sw_wr      = ($urandom % 3) == 0;
      sw_wdata   = DW'($urandom);
      tx_req     = ($urandom % 4) == 0;
      addr_match = ($urandom % 23) == 0;
      addr_clr   = ($urandom % 5) == 0;
      err_clr    = ($urandom % 7) == 0;
      step("R4 R7 R11 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule